// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block controls one bank of general-purpose pins through a small word-addressed register bus. Software sets the value each pin drives and whether its driver is on. It reads back the pin levels after they have been brought safely into the clock domain. Each pin can also raise an interrupt, and software chooses per pin whether that interrupt is caused by a level, a rising edge, a falling edge or any edge.

Interrupt causes latch into a per-pin raw status vector. A per-pin enable vector masks them, and the masked result can be read as a register of its own. A single `irq` output is the OR of all masked bits. Software acknowledges a pin by writing a one to its position in the acknowledge register. A pin whose level condition still holds, or whose new edge lands in the same cycle as the acknowledge, stays latched.

The bus is a simple read and write port that shares one address. A write takes effect at the clock edge where it is presented. Read data comes back registered, one cycle after the read strobe, together with `bus_rvalid`.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous active-high reset every register reads 0, `pin_oe` is all zero and `irq` is low. With these zeros every pin is an input, edge-sensed on falling edges, and masked.
- R2: The drive-value word (byte offset 0x04) appears on `pin_out` and the drive-enable word (0x08) appears on `pin_oe`, bit n for pin n, from the clock edge that accepts the write. Both words read back as written. A 1 in drive-enable means the pin drives its drive-value bit; a 0 means the pin is an input.
- R3: Offset 0x00 returns `pin_in` after a two-flop synchroniser. A read strobe presented in the same cycle as a pin change, or one cycle later, still returns the old value. A strobe presented two cycles after the change returns the new value.
- R4: When the level-select bit (0x0C) and the any-edge bit (0x10) of a pin are both 0, a polarity bit (0x14) of 1 latches the raw status bit (0x1C) on a synchronised rising edge of that pin. A polarity bit of 0 latches it on a falling edge. The opposite edge latches nothing.
- R5: When the any-edge bit of an edge-sensed pin is 1, both rising and falling edges latch its status, whatever its polarity bit holds.
- R6: When the level-select bit is 1, the status bit is set on every cycle in which the synchronised pin equals its polarity bit (1 = active high, 0 = active low). The bit stays latched after the level goes away, and it cannot be acknowledged while the level is still active.
- R7: The pending word (0x20) reads as raw status AND the enable word (0x18, 1 = enabled). `irq` is high exactly when a pending bit is set.
- R8: Writing the acknowledge word (0x24) clears each raw status bit written as 1 and leaves each bit written as 0 untouched. The acknowledge word itself reads 0.
- R9: An event that arrives in the same cycle as an acknowledge of its bit leaves that bit set.
- R10: Writes to 0x00, 0x1C, 0x20, to unmapped offsets or to addresses whose low two bits are not zero change nothing. Reads of unmapped or misaligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address shared by read and write |
| bus_wdata | input | NUM_PINS | Write data |
| bus_rdata | output | NUM_PINS | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after a read strobe |
| pin_in | input | NUM_PINS | Pin levels, asynchronous to clk |
| pin_out | output | NUM_PINS | Value each pin drives |
| pin_oe | output | NUM_PINS | Per-pin driver enable |
| irq | output | 1 | OR of all enabled, latched causes |

## Verification
The bench builds the block with its defaults: 32 pins, an 8-bit byte address and two synchroniser stages. With these values the full word reaches bit 31 in the drive patterns, and the three-cycle path from a pin change to latched status is fixed, so the test can place an acknowledge exactly on the cycle in which an edge is recognised. The modes are exercised on disjoint pins at the same time. Falling-edge, rising-edge, any-edge and both level polarities therefore each show up as a distinct bit in one raw status word, and an edge of the wrong direction appears as a bit that must stay clear.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Word indices of the register map (byte offset = index * 4).
    localparam int W_PIN_IN    = 0;
    localparam int W_DRV_VAL   = 1;
    localparam int W_DRV_EN    = 2;
    localparam int W_SENSE_LVL = 3;
    localparam int W_BOTH_EDGE = 4;
    localparam int W_POLARITY  = 5;
    localparam int W_IRQ_EN    = 6;
    localparam int W_RAW       = 7;
    localparam int W_PEND      = 8;
    localparam int W_ACK       = 9;

    typedef struct packed {
        logic level;   // 1: level sensed, 0: edge sensed
        logic both;    // any edge when edge sensed
        logic high;    // rising / active high when 1
    } pin_sense_t;

    typedef enum logic [1:0] {
        SK_FALL  = 2'd0,
        SK_RISE  = 2'd1,
        SK_ANY   = 2'd2,
        SK_LEVEL = 2'd3
    } sense_kind_e;

    function automatic sense_kind_e sense_kind(pin_sense_t s);
        if (s.level)     return SK_LEVEL;
        else if (s.both) return SK_ANY;
        else if (s.high) return SK_RISE;
        else             return SK_FALL;
    endfunction

    function automatic logic sense_event(pin_sense_t s, logic cur, logic prev);
        logic ev;
        case (sense_kind(s))
            SK_LEVEL: ev = (cur == s.high);
            SK_ANY:   ev = cur ^ prev;
            SK_RISE:  ev = cur & ~prev;
            default:  ev = ~cur & prev;
        endcase
        return ev;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= '0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] drv_val,
    output logic [NUM_PINS-1:0] drv_en,
    output logic [NUM_PINS-1:0] lvl_sel,
    output logic [NUM_PINS-1:0] any_edge,
    output logic [NUM_PINS-1:0] polarity,
    output logic [NUM_PINS-1:0] irq_en,
    output logic [NUM_PINS-1:0] ack_bits,
    output pin_sense_t          sense [NUM_PINS]
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] widx;
    logic              wr_go;

    assign widx  = addr[ADDR_W-1:2];
    assign wr_go = wr_en && (addr[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_val  <= '0;
            drv_en   <= '0;
            lvl_sel  <= '0;
            any_edge <= '0;
            polarity <= '0;
            irq_en   <= '0;
        end else if (wr_go) begin
            case (widx)
                WORD_W'(W_DRV_VAL):   drv_val  <= wdata;
                WORD_W'(W_DRV_EN):    drv_en   <= wdata;
                WORD_W'(W_SENSE_LVL): lvl_sel  <= wdata;
                WORD_W'(W_BOTH_EDGE): any_edge <= wdata;
                WORD_W'(W_POLARITY):  polarity <= wdata;
                WORD_W'(W_IRQ_EN):    irq_en   <= wdata;
                default: ;
            endcase
        end
    end

    assign ack_bits = (wr_go && widx == WORD_W'(W_ACK)) ? wdata : '0;

    genvar g;
    generate
        for (g = 0; g < NUM_PINS; g++) begin : g_sense
            assign sense[g] = '{level: lvl_sel[g], both: any_edge[g], high: polarity[g]};
        end
    endgenerate
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_now,
    input  pin_sense_t          sense [NUM_PINS],
    input  logic [NUM_PINS-1:0] ack_bits,
    output logic [NUM_PINS-1:0] hit,
    output logic [NUM_PINS-1:0] raw
);
    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_now;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_PINS; g++) begin : g_pin
            assign hit[g] = sense_event(sense[g], pin_now[g], prev_q[g]);

            // A fresh event outranks an acknowledge in the same cycle.
            always_ff @(posedge clk) begin
                if (rst) raw[g] <= 1'b0;
                else     raw[g] <= (raw[g] & ~ack_bits[g]) | hit[g];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr_en,
    input  logic                bus_rd_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    output logic                bus_rvalid,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int WORD_W = ADDR_W - 2;

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] drv_val, drv_en, lvl_sel, any_edge, polarity, irq_en;
    logic [NUM_PINS-1:0] ack_bits, sense_hit, stat_raw, stat_pend;
    pin_sense_t          sense [NUM_PINS];
    logic [NUM_PINS-1:0] rd_mux;
    logic [WORD_W-1:0]   ridx;

    gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_regfile #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .drv_val  (drv_val),
        .drv_en   (drv_en),
        .lvl_sel  (lvl_sel),
        .any_edge (any_edge),
        .polarity (polarity),
        .irq_en   (irq_en),
        .ack_bits (ack_bits),
        .sense    (sense)
    );

    gpio_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .pin_now  (pin_sync),
        .sense    (sense),
        .ack_bits (ack_bits),
        .hit      (sense_hit),
        .raw      (stat_raw)
    );

    assign stat_pend = stat_raw & irq_en;
    assign irq       = |stat_pend;
    assign pin_out   = drv_val;
    assign pin_oe    = drv_en;

    assign ridx = bus_addr[ADDR_W-1:2];

    always_comb begin
        rd_mux = '0;
        if (bus_addr[1:0] == 2'b00) begin
            case (ridx)
                WORD_W'(W_PIN_IN):    rd_mux = pin_sync;
                WORD_W'(W_DRV_VAL):   rd_mux = drv_val;
                WORD_W'(W_DRV_EN):    rd_mux = drv_en;
                WORD_W'(W_SENSE_LVL): rd_mux = lvl_sel;
                WORD_W'(W_BOTH_EDGE): rd_mux = any_edge;
                WORD_W'(W_POLARITY):  rd_mux = polarity;
                WORD_W'(W_IRQ_EN):    rd_mux = irq_en;
                WORD_W'(W_RAW):       rd_mux = stat_raw;
                WORD_W'(W_PEND):      rd_mux = stat_pend;
                default:              rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd_en;
            if (bus_rd_en) bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [NUM_PINS-1:0] wdata,
    input logic [NUM_PINS-1:0] oe,
    input logic                irq,
    input logic [NUM_PINS-1:0] hit,
    input logic [NUM_PINS-1:0] raw,
    input logic [NUM_PINS-1:0] mask
);
    localparam logic [ADDR_W-1:0] OE_ADDR  = ADDR_W'(W_DRV_EN * 4);
    localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(W_ACK * 4);

    // R1: reset leaves the interrupt low and all drivers off
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!irq && oe == '0));

    // R2: drive enables only move on a write to their word
    p_oe_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == OE_ADDR) |=> $stable(oe));

    // R4: no status bit appears without a detected event
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
        (hit == '0) |=> ((raw & ~$past(raw)) == '0));

    // R7: nothing enabled and latched means no interrupt
    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ((raw & mask) == '0) |-> !irq);

    // R8: acknowledged bits without a new event are cleared
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ACK_ADDR) |=> ((raw & $past(wdata & ~hit)) == '0));

    // R9: every detected event is latched, acknowledge or not
    p_event_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |=> ((raw & $past(hit)) == $past(hit)));
endmodule

bind gpio_irq_bank gpio_bank_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_checker (
    .clk   (clk),
    .rst   (rst),
    .wr_en (bus_wr_en),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .oe    (pin_oe),
    .irq   (irq),
    .hit   (sense_hit),
    .raw   (stat_raw),
    .mask  (irq_en)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;
    localparam int AW = 8;

    localparam logic [7:0] A_IN = 8'h00, A_DV = 8'h04, A_DE = 8'h08, A_LV = 8'h0C,
                           A_BE = 8'h10, A_PO = 8'h14, A_EN = 8'h18, A_RAW = 8'h1C,
                           A_PEND = 8'h20, A_ACK = 8'h24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0, pin_in = '0;
    logic [NP-1:0] bus_rdata, pin_out, pin_oe;
    logic          bus_rvalid, irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [7:0]    addr;
        logic [NP-1:0] exp;
        string         tag;
    } sb_item_t;
    sb_item_t sbq[$];

    gpio_irq_bank uut (
        .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pops expectations as read data returns.
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            n_cmp++;
            if (sbq.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected read data %h", bus_rdata);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s addr %h: got %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [NP-1:0] d);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [NP-1:0] e, input string tag);
        sb_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", {31'b0, irq}, '0);
        chk("R1 pin_oe", pin_oe, '0);
        for (int i = 0; i < 10; i++) rd(8'(i * 4), '0, "R1 reset value");

        // R2: drive value and enable
        wr(A_DV, 32'hA5A5_0F0F);
        wr(A_DE, 32'hFFFF_0000);
        chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        rd(A_DV, 32'hA5A5_0F0F, "R2 readback value");
        rd(A_DE, 32'hFFFF_0000, "R2 readback enable");

        // R3: synchroniser latency
        pin_in = 32'h1234_5678;
        rd(A_IN, 32'h0, "R3 same cycle");
        rd(A_IN, 32'h0, "R3 one later");
        rd(A_IN, 32'h1234_5678, "R3 two later");
        pin_in = '0;
        settle();
        wr(A_ACK, '1);
        rd(A_RAW, '0, "R8 full ack");

        // R4: single edge, polarity on bit0 rising, bit1 falling
        wr(A_PO, 32'h1);
        pin_in = 32'h3;
        settle();
        rd(A_RAW, 32'h1, "R4 rising only");
        pin_in = 32'h0;
        settle();
        rd(A_RAW, 32'h3, "R4 falling latched");
        wr(A_ACK, 32'h1);
        rd(A_RAW, 32'h2, "R8 one-bit ack");
        wr(A_ACK, 32'h0);
        rd(A_RAW, 32'h2, "R8 zero ack keeps");
        rd(A_ACK, 32'h0, "R8 ack reads zero");
        wr(A_ACK, '1);

        // R5: any edge on bit2, polarity 0 ignored
        wr(A_BE, 32'h4);
        pin_in = 32'h4;
        settle();
        rd(A_RAW, 32'h4, "R5 rising with any-edge");
        wr(A_ACK, 32'h4);
        pin_in = 32'h0;
        settle();
        rd(A_RAW, 32'h4, "R5 falling with any-edge");
        wr(A_ACK, '1);
        wr(A_BE, 32'h0);

        // R6: level, bit4 active high, bit5 active low
        wr(A_PO, 32'h11);
        wr(A_LV, 32'h30);
        settle();
        rd(A_RAW, 32'h20, "R6 active low at idle");
        pin_in = 32'h10;
        settle();
        rd(A_RAW, 32'h30, "R6 active high");
        wr(A_ACK, 32'h30);
        rd(A_RAW, 32'h30, "R6 ack while active");
        pin_in = 32'h20;
        settle();
        rd(A_RAW, 32'h30, "R6 latched after inactive");
        wr(A_ACK, 32'h30);
        rd(A_RAW, 32'h0, "R6 ack after inactive");
        wr(A_LV, 32'h0);
        wr(A_PO, 32'h1);
        pin_in = 32'h0;
        settle();
        wr(A_ACK, '1);

        // R7: mask, pending, irq
        pin_in = 32'h3;
        settle();
        pin_in = 32'h0;
        settle();
        rd(A_RAW, 32'h3, "R7 raw setup");
        chk("R7 masked irq low", {31'b0, irq}, '0);
        wr(A_EN, 32'h2);
        chk("R7 irq high", {31'b0, irq}, 32'h1);
        rd(A_PEND, 32'h2, "R7 pending");
        wr(A_ACK, 32'h2);
        chk("R7 irq after ack", {31'b0, irq}, '0);
        rd(A_RAW, 32'h1, "R7 raw after ack");
        wr(A_EN, 32'h0);
        wr(A_ACK, '1);

        // R9: edge recognised in the cycle of the acknowledge
        pin_in = 32'h1;
        settle();
        pin_in = 32'h0;
        settle();
        rd(A_RAW, 32'h1, "R9 setup");
        pin_in = 32'h1;
        @(negedge clk);
        @(negedge clk);
        wr(A_ACK, 32'h1);
        rd(A_RAW, 32'h1, "R9 event beats ack");
        wr(A_ACK, 32'h1);
        rd(A_RAW, 32'h0, "R8 plain ack");

        // R10: read-only, unmapped and misaligned accesses
        wr(A_RAW, '1);
        wr(A_PEND, '1);
        wr(A_IN, '1);
        wr(8'h3C, '1);
        wr(A_DV + 8'h1, 32'h0);
        rd(A_RAW, 32'h0, "R10 raw unwritable");
        rd(A_PEND, 32'h0, "R10 pend unwritable");
        rd(A_IN, 32'h1, "R10 input unwritable");
        rd(A_DV, 32'hA5A5_0F0F, "R10 misaligned write ignored");
        rd(8'h3C, 32'h0, "R10 unmapped read");
        rd(A_DV + 8'h2, 32'h0, "R10 misaligned read");

        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard left %0d items", sbq.size());
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule